// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

This block is a chip-level watchdog built on a 64-bit up-counter that sits in two 32-bit register halves. Software sets the counter and a 64-bit terminal period while the watchdog is idle. It then opens the watchdog with an ordered pair of 16-bit magic keys. The keys go into the upper half of a dedicated control register. Once live, the counter advances by one every clock. If it reaches the period, the block pulls its reset output high for a fixed number of cycles and then falls back to idle.

Software keeps the watchdog from firing by writing the same two keys again, first then second, which returns the counter to zero. Any other key value written while live is treated as tampering, and the reset fires on the next edge. The watchdog only opens when the global control register selects watchdog timer mode with both halves running. While the watchdog is anything other than idle, that register, the counter and the period are all locked against writes.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, every register reads 0 and `wdRst` is low.
- R2: In idle, writes to global control (offset 0, bits 3:0), counter low/high (offsets 1/2) and period low/high (offsets 3/4) are stored and read back. Unused offsets read 0. In any other state these writes are ignored.
- R3: Writing offset 5 with bit 14 set and key field bits 31:16 = 0xA5C6 moves idle to the armed state (code 1), but only when global control holds mode bits 3:2 = 2 and run bits 1:0 = 3 (value 0xB). Otherwise the state stays idle and bit 14 is simply stored.
- R4: In the armed state, key 0xDA7E moves the watchdog to live (code 2). A write with bit 14 clear returns it to idle with enable cleared. Any other write leaves the state unchanged.
- R5: While live, the 64-bit counter advances by one per clock, and the carry propagates from the low word into the high word.
- R6: While live, a write of 0xA5C6 followed later by a write of 0xDA7E clears the counter on the 0xDA7E write. A 0xDA7E write with no 0xA5C6 before it since the last clear leaves the count running.
- R7: While live, a write to offset 5 whose key is neither 0xA5C6 nor 0xDA7E moves the watchdog to fired (code 3), and `wdRst` is high from the following cycle.
- R8: While live, if the counter equals the period at a clock edge, the watchdog fires and the counter holds. This takes priority over a key write in the same cycle.
- R9: `wdRst` stays high for exactly RST_HOLD cycles. The watchdog then returns to idle with enable cleared and the counter at 0.
- R10: While live, bit 14 cannot be cleared by a write; it reads 1.
- R11: Offset 5 reads back the enable at bit 14 and the state code at bits 1:0. Every other bit, including the key field, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset for write and read |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` (combinational) |
| wdRst | output | 1 | Chip reset request |

## Verification
The bench builds the block with the default 32-bit data width, which gives the full 64-bit counter, and with RST_HOLD reduced to 6 so that whole fire-and-recover sequences fit into short runs. Counter preloads just below a word boundary bring the low-to-high carry within a few dozen cycles. Small periods make the terminal-count edge reachable, including the case where a service key lands on that same edge. The default key values are kept, so wrong-key and missing-first-key cases are driven with the real magic numbers.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LIVE  = 2'd2,
    ST_FIRED = 2'd3
  } wdState_e;

  typedef struct packed {
    logic cfgWrOk;   // configuration registers writable
    logic cntRun;    // advance counter this edge
    logic cntClear;  // zero counter this edge
  } wdStrobe_t;

  localparam int REG_GLB    = 0;
  localparam int REG_CNT_LO = 1;
  localparam int REG_CNT_HI = 2;
  localparam int REG_PRD_LO = 3;
  localparam int REG_PRD_HI = 4;
  localparam int REG_WDC    = 5;

  localparam int GLB_W = 4;
  localparam logic [GLB_W-1:0] GLB_WD_CFG = 4'b1011;  // mode 2, both halves running
  localparam int EN_BIT = 14;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  wdStrobe_t         stb,
  input  wdState_e          stateQ,
  input  logic              enableQ,
  output logic [DATA_W-1:0] rdData,
  output logic              termHit,
  output logic              wdConfig,
  output logic [CNT_W-1:0]  cntVal
);

  logic [GLB_W-1:0] glbQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] prdQ;
  logic             cfgWr;

  assign cfgWr = wrEn && stb.cfgWrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbQ <= '0;
      cntQ <= '0;
      prdQ <= '0;
    end else begin
      if (stb.cntClear)
        cntQ <= '0;
      else if (stb.cntRun)
        cntQ <= cntQ + CNT_W'(1);
      else if (cfgWr && addr == ADDR_W'(REG_CNT_LO))
        cntQ[DATA_W-1:0] <= wrData;
      else if (cfgWr && addr == ADDR_W'(REG_CNT_HI))
        cntQ[CNT_W-1:DATA_W] <= wrData;

      if (cfgWr && addr == ADDR_W'(REG_GLB))
        glbQ <= wrData[GLB_W-1:0];
      if (cfgWr && addr == ADDR_W'(REG_PRD_LO))
        prdQ[DATA_W-1:0] <= wrData;
      if (cfgWr && addr == ADDR_W'(REG_PRD_HI))
        prdQ[CNT_W-1:DATA_W] <= wrData;
    end
  end

  assign termHit  = (cntQ == prdQ);
  assign wdConfig = (glbQ == GLB_WD_CFG);
  assign cntVal   = cntQ;

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_GLB):    rdData[GLB_W-1:0] = glbQ;
      ADDR_W'(REG_CNT_LO): rdData = cntQ[DATA_W-1:0];
      ADDR_W'(REG_CNT_HI): rdData = cntQ[CNT_W-1:DATA_W];
      ADDR_W'(REG_PRD_LO): rdData = prdQ[DATA_W-1:0];
      ADDR_W'(REG_PRD_HI): rdData = prdQ[CNT_W-1:DATA_W];
      ADDR_W'(REG_WDC): begin
        rdData[EN_BIT] = enableQ;
        rdData[1:0]    = stateQ;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY1 = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY2 = 16'hDA7E,
  parameter int RST_HOLD = 16,
  localparam int HOLD_W = $clog2(RST_HOLD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [KEY_W-1:0] keyIn,
  input  logic             enIn,
  input  logic             termHit,
  input  logic             wdConfig,
  output wdState_e         stateQ,
  output logic             enableQ,
  output wdStrobe_t        stb
);

  wdState_e          stateD;
  logic              enableD;
  logic              svcQ, svcD;
  logic [HOLD_W-1:0] holdQ, holdD;
  logic              isKey1, isKey2;

  assign isKey1 = (keyIn == KEY1);
  assign isKey2 = (keyIn == KEY2);

  always_comb begin
    stateD       = stateQ;
    enableD      = enableQ;
    svcD         = svcQ;
    holdD        = holdQ;
    stb.cfgWrOk  = (stateQ == ST_IDLE);
    stb.cntRun   = 1'b0;
    stb.cntClear = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (ctlWr) begin
          enableD = enIn;
          if (enIn && isKey1 && wdConfig) stateD = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (ctlWr) begin
          if (!enIn) begin
            stateD  = ST_IDLE;
            enableD = 1'b0;
          end else if (isKey2) begin
            stateD = ST_LIVE;
            svcD   = 1'b0;
          end
        end
      end
      ST_LIVE: begin
        if (termHit || (ctlWr && !isKey1 && !isKey2)) begin
          stateD = ST_FIRED;
          holdD  = '0;
        end else begin
          stb.cntRun = 1'b1;
          if (ctlWr && isKey2 && svcQ) begin
            stb.cntClear = 1'b1;
            svcD         = 1'b0;
          end else if (ctlWr && isKey1) begin
            svcD = 1'b1;
          end
        end
      end
      ST_FIRED: begin
        if (holdQ == HOLD_W'(RST_HOLD - 1)) begin
          stateD       = ST_IDLE;
          enableD      = 1'b0;
          svcD         = 1'b0;
          stb.cntClear = 1'b1;
        end else begin
          holdD = holdQ + HOLD_W'(1);
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      enableQ <= 1'b0;
      svcQ    <= 1'b0;
      holdQ   <= '0;
    end else begin
      stateQ  <= stateD;
      enableQ <= enableD;
      svcQ    <= svcD;
      holdQ   <= holdD;
    end
  end

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY1 = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY2 = 16'hDA7E,
  parameter int RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wdRst
);

  localparam int CNT_W = 2 * DATA_W;

  wdStrobe_t        stb;
  wdState_e         stateQ;
  logic             enableQ;
  logic             termHit;
  logic             wdConfig;
  logic             ctlWr;
  logic [CNT_W-1:0] cntVal;

  assign ctlWr = wrEn && (addr == ADDR_W'(REG_WDC));

  wdog_control #(
    .KEY_W(KEY_W), .KEY1(KEY1), .KEY2(KEY2), .RST_HOLD(RST_HOLD)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr),
    .keyIn(wrData[DATA_W-1 -: KEY_W]), .enIn(wrData[EN_BIT]),
    .termHit(termHit), .wdConfig(wdConfig),
    .stateQ(stateQ), .enableQ(enableQ), .stb(stb)
  );

  wdog_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .stb(stb), .stateQ(stateQ), .enableQ(enableQ),
    .rdData(rdData), .termHit(termHit), .wdConfig(wdConfig), .cntVal(cntVal)
  );

  assign wdRst = (stateQ == ST_FIRED);

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int RST_HOLD = 16,
  localparam int CNT_W = 2 * DATA_W,
  localparam int RUN_W = $clog2(RST_HOLD + 2)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              wdRst,
  input wdState_e          stateQ,
  input logic              enableQ,
  input logic [CNT_W-1:0]  cntVal
);

  logic [RUN_W-1:0] rstRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstRun <= '0;
    else if (wdRst) rstRun <= rstRun + RUN_W'(1);
    else rstRun <= '0;
  end

  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(REG_WDC)) |-> (rdData[DATA_W-1:16] == '0)); // R11

  AST_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LIVE) |-> enableQ); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_LIVE && stateQ == ST_LIVE) |->
      (cntVal == $past(cntVal) + CNT_W'(1) || cntVal == '0)); // R5

  AST_FIRE_FROM_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdRst) |-> ($past(stateQ) == ST_LIVE)); // R7

  AST_HOLD_MAX: assert property (@(posedge clk) disable iff (!rstN)
    wdRst |-> (rstRun < RUN_W'(RST_HOLD))); // R9

  AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdRst) |-> (rstRun == RUN_W'(RST_HOLD))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE) |-> !wdRst); // R1

endmodule

bind keyed_wdog wdog_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD)
) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData), .wdRst(wdRst),
  .stateQ(stateQ), .enableQ(enableQ), .cntVal(cntVal)
);

// File: tb/test_keyed_wdog.sv
`timescale 1ns/1ps
module test_keyed_wdog;

  localparam int HOLD = 6;
  localparam logic [15:0] K1 = 16'hA5C6;
  localparam logic [15:0] K2 = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        wdRst;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int       mSt = 0;
  bit       mEn = 0;
  bit       mSvc = 0;
  bit [63:0] mCnt = 0;
  bit [63:0] mPrd = 0;
  bit [3:0] mGlb = 0;
  int       mHold = 0;

  always #2.5 clk = ~clk;

  keyed_wdog #(.RST_HOLD(HOLD)) i_keyed_wdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .wdRst(wdRst)
  );

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, mGlb};
      3'd1: return mCnt[31:0];
      3'd2: return mCnt[63:32];
      3'd3: return mPrd[31:0];
      3'd4: return mPrd[63:32];
      3'd5: return (32'(mEn) << 14) | 32'(mSt);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mEn = 0; mSvc = 0; mCnt = 0; mPrd = 0; mGlb = 0; mHold = 0;
    end else begin
      bit       isCtl;
      bit [15:0] key;
      isCtl = wrEn && addr == 3'd5;
      key   = wrData[31:16];
      case (mSt)
        0: begin
          if (wrEn) begin
            if (addr == 3'd0) mGlb = wrData[3:0];
            if (addr == 3'd1) mCnt[31:0] = wrData;
            if (addr == 3'd2) mCnt[63:32] = wrData;
            if (addr == 3'd3) mPrd[31:0] = wrData;
            if (addr == 3'd4) mPrd[63:32] = wrData;
          end
          if (isCtl) begin
            mEn = wrData[14];
            if (wrData[14] && key == K1 && mGlb == 4'hB) mSt = 1;
          end
        end
        1: if (isCtl) begin
          if (!wrData[14]) begin mSt = 0; mEn = 0; end
          else if (key == K2) begin mSt = 2; mSvc = 0; end
        end
        2: begin
          if (mCnt == mPrd || (isCtl && key != K1 && key != K2)) begin
            mSt = 3; mHold = 0;
          end else if (isCtl && key == K2 && mSvc) begin
            mCnt = 0; mSvc = 0;
          end else begin
            mCnt = mCnt + 1;
            if (isCtl && key == K1) mSvc = 1;
          end
        end
        default: begin
          if (mHold == HOLD - 1) begin
            mSt = 0; mEn = 0; mSvc = 0; mCnt = 0;
          end else mHold = mHold + 1;
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, just after each edge
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("MODEL R7 R8 R9 wdRst", {31'd0, wdRst}, {31'd0, (mSt == 3)});
      chk("MODEL R2 R5 R11 rdData", rdData, expRead(addr));
    end
  end

  // tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    @(posedge clk); #1;
    v = rdData;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, 32'd0);
    end
    chk("R1 wdRst low", {31'd0, wdRst}, 32'd0);

    // R3 arming refused without watchdog mode
    wr(3'd5, {K1, 16'h4000});
    rd(3'd5, v);
    chk("R3 no arm without mode", v, 32'h0000_4000);

    // R2 configuration in idle
    wr(3'd0, 32'hFFFF_FFFB);
    rd(3'd0, v);
    chk("R2 global ctrl", v, 32'h0000_000B);
    wr(3'd1, 32'hFFFF_FFF0);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h0000_0100);
    wr(3'd4, 32'd1);
    rd(3'd1, v); chk("R2 cnt lo", v, 32'hFFFF_FFF0);
    rd(3'd4, v); chk("R2 prd hi", v, 32'd1);

    // R3 arm, R11 readback
    wr(3'd5, {K1, 16'h4000});
    rd(3'd5, v);
    chk("R3 R11 armed", v, 32'h0000_4001);
    // R4 other key ignored while armed, R2 lock
    wr(3'd5, {16'h1234, 16'h4000});
    rd(3'd5, v); chk("R4 armed stays", v, 32'h0000_4001);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R2 locked glb", v, 32'h0000_000B);

    // R4 activate
    wr(3'd5, {K2, 16'h4000});
    rd(3'd5, v); chk("R4 live", v, 32'h0000_4002);
    idle(20);
    // R5 carry into high word: low was near wrap
    rd(3'd2, v); chk("R5 carry high", v, 32'd1);

    // R10 enable sticky; R6 lone second key no clear
    wr(3'd5, {K2, 16'h0000});
    rd(3'd5, v); chk("R10 enable sticky", v, 32'h0000_4002);
    rd(3'd2, v); chk("R6 lone key2 no clear", v, 32'd1);

    // R6 service
    wr(3'd5, {K1, 16'h4000});
    wr(3'd5, {K2, 16'h4000});
    rd(3'd1, v); chk("R6 service cleared", v, 32'd1);
    rd(3'd2, v); chk("R6 service high", v, 32'd0);

    // R7 wrong key fires
    wr(3'd5, {16'h0BAD, 16'h4000});
    chk("R7 wrong key", {31'd0, wdRst}, 32'd1);
    rd(3'd5, v); chk("R7 fired code", v, 32'h0000_4003);
    // R9 hold length: high at entry + 1 read edge, so HOLD-2 more
    idle(HOLD - 2);
    chk("R9 still high", {31'd0, wdRst}, 32'd1);
    idle(1);
    chk("R9 released", {31'd0, wdRst}, 32'd0);
    rd(3'd5, v); chk("R9 back idle", v, 32'd0);
    rd(3'd1, v); chk("R9 counter zero", v, 32'd0);

    // R8 terminal count with period 20
    wr(3'd3, 32'd20);
    wr(3'd4, 32'd0);
    wr(3'd5, {K1, 16'h4000});
    wr(3'd5, {K2, 16'h4000});
    idle(20);
    chk("R8 not yet", {31'd0, wdRst}, 32'd0);
    idle(1);
    chk("R8 terminal fire", {31'd0, wdRst}, 32'd1);
    rd(3'd1, v); chk("R8 counter held", v, 32'd20);
    idle(HOLD);

    // R8 terminal beats service key on the same edge
    wr(3'd3, 32'd5);
    wr(3'd5, {K1, 16'h4000});
    wr(3'd5, {K2, 16'h4000});
    idle(4);
    wr(3'd5, {K1, 16'h4000});
    wr(3'd5, {K2, 16'h4000});
    chk("R8 priority over service", {31'd0, wdRst}, 32'd1);
    idle(HOLD + 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule